// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup

This block resolves the next hop for a destination key by longest-prefix match. It does not compare prefixes against the key. Instead it performs two table reads in a fixed pipeline. The upper part of the key selects an entry in a large first-level table. That entry either yields a next hop directly, or it names one of several second-level blocks. The remaining low bits of the key then select an entry inside that block. Prefix lengths never need to be known at lookup time. Control software expands every route into the tables before lookups run: short prefixes are replicated across all first-level entries they cover, and longer prefixes are written after shorter ones so that they overwrite them.

Requests arrive as a valid/key stream and may come on every clock cycle. Results leave in request order after a constant delay, each one carrying a hit flag and a next-hop index. A single write port installs first-level and second-level entries. The full-size configuration uses a 32-bit key split 24/8. Reduced splits are obtained through parameters.

Top module: `route_lookup_2lvl`

## Requirements
- R1: For every key, a hit result carries the next hop of the longest installed prefix that covers the key, where prefixes up to L1_W bits live in first-level entries and longer ones in second-level entries.
- R2: A valid first-level entry with its pointer flag at 0 gives a hit whose next hop is the low NH_W bits of that entry's payload, and the second-level contents do not affect the result.
- R3: A first-level entry with its pointer flag at 1 selects a second-level block, and the block number is the low PTR_W bits of its payload. The key's low L2_W bits then pick the entry, at second-level address {block, low bits}.
- R4: When the deciding entry (the first-level entry, or the second-level entry it points to) has its valid bit clear, the result has res_hit = 0 and res_hop = DEFAULT_HOP.
- R5: A new request is accepted on every cycle with no stall, and results leave in exactly the order the requests came in.
- R6: Each result appears exactly 3 cycles after its request is sampled, and res_valid is never raised without a matching request.
- R7: A lookup that is sampled in the same cycle as a write to the entry it reads returns the value that entry held before the write. This holds for both levels.
- R8: A lookup issued in the cycle after a write sees the written value. wr_level = 0 selects the first level at wr_addr[L1_W-1:0]; wr_level = 1 selects the second level.
- R9: When an entry is written more than once, the last write decides the lookup result. This lets a longer route overwrite a replicated shorter one.
- R10: While reset is held, and in the cycle after it, res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_key | input | KEY_W | Destination key (L1_W + L2_W bits) |
| wr_en | input | 1 | Table write strobe |
| wr_level | input | 1 | 0 = first-level table, 1 = second-level table |
| wr_addr | input | WA_W | Entry address: first-level index, or {block, low bits} |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_ptr | input | 1 | Pointer flag (first level only) |
| wr_payload | input | PAY_W | Next hop, or block number when wr_ptr is 1 |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A route matched |
| res_hop | output | NH_W | Next-hop index, or DEFAULT_HOP on a miss |

## Verification
The bench builds the block with L1_W = 6, L2_W = 4 and PTR_W = 2, which gives a 10-bit key. At that size, all 1024 keys can be looked up back to back and each result compared against a brute-force longest-prefix search over the route list. The route set covers several things: prefixes shorter than, equal to and longer than the first-level width; nested routes; and an uncovered region in which second-level entries are left invalid. Write collisions are checked at both levels with the lookup issued in the same cycle as the write and in the cycle after it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic {
    LVL_FIRST  = 1'b0,
    LVL_SECOND = 1'b1
  } lvl_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lpm_ram.sv
module lpm_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first single-port-style behaviour: a same-edge read sees old data.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lpm_resolve.sv
module lpm_resolve #(
  parameter int               NH_W        = 8,
  parameter logic [NH_W-1:0]  DEFAULT_HOP = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_l1_valid,
  input  logic            in_l1_ptr,
  input  logic [NH_W-1:0] in_l1_hop,
  input  logic            in_l2_valid,
  input  logic [NH_W-1:0] in_l2_hop,
  output logic            out_valid,
  output logic            out_hit,
  output logic [NH_W-1:0] out_hop
);
  logic            hit_c;
  logic [NH_W-1:0] hop_c;

  always_comb begin
    if (in_l1_ptr) begin
      hit_c = in_l1_valid & in_l2_valid;
      hop_c = hit_c ? in_l2_hop : DEFAULT_HOP;
    end else begin
      hit_c = in_l1_valid;
      hop_c = hit_c ? in_l1_hop : DEFAULT_HOP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_hop   <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= hit_c;
      out_hop   <= hop_c;
    end
  end
endmodule

// File: rtl/route_lookup_2lvl.sv
module route_lookup_2lvl
  import lpm_pkg::*;
#(
  parameter int              L1_W        = 10,
  parameter int              L2_W        = 8,
  parameter int              PTR_W       = 3,
  parameter int              NH_W        = 8,
  parameter logic [NH_W-1:0] DEFAULT_HOP = '0,
  localparam int             KEY_W       = L1_W + L2_W,
  localparam int             L2A_W       = PTR_W + L2_W,
  localparam int             WA_W        = (L1_W > L2A_W) ? L1_W : L2A_W,
  localparam int             PAY_W       = (NH_W > PTR_W) ? NH_W : PTR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_key,
  input  logic             wr_en,
  input  logic             wr_level,
  input  logic [WA_W-1:0]  wr_addr,
  input  logic             wr_valid,
  input  logic             wr_ptr,
  input  logic [PAY_W-1:0] wr_payload,
  output logic             res_valid,
  output logic             res_hit,
  output logic [NH_W-1:0]  res_hop
);
  localparam int L1D_W = PAY_W + 2;  // {valid, ptr, payload}
  localparam int L2D_W = NH_W + 1;   // {valid, hop}

  // ---------------- write decode ----------------
  logic             l1_we;
  logic [L1D_W-1:0] l1_wdata;
  assign l1_we    = wr_en && (wr_level == LVL_FIRST);
  assign l1_wdata = {wr_valid, wr_ptr, wr_payload};

  // Second-level writes are delayed one cycle so that a lookup issued in the
  // write cycle (which reads level 2 one edge later) still sees old data.
  logic             l2w_en;
  logic [L2A_W-1:0] l2w_addr;
  logic [L2D_W-1:0] l2w_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      l2w_en   <= 1'b0;
      l2w_addr <= '0;
      l2w_data <= '0;
    end else begin
      l2w_en   <= wr_en && (wr_level == LVL_SECOND);
      l2w_addr <= wr_addr[L2A_W-1:0];
      l2w_data <= {wr_valid, wr_payload[NH_W-1:0]};
    end
  end

  // ---------------- stage 1: first-level read ----------------
  logic [L1D_W-1:0] l1_rd;
  logic             s1_valid;
  logic [L2_W-1:0]  s1_low;

  lpm_ram #(.AW(L1_W), .DW(L1D_W)) l1_ram_i (
    .clk   (clk),
    .we    (l1_we),
    .waddr (wr_addr[L1_W-1:0]),
    .wdata (l1_wdata),
    .raddr (req_key[KEY_W-1:L2_W]),
    .rdata (l1_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_low   <= '0;
    end else begin
      s1_valid <= req_valid;
      s1_low   <= req_key[L2_W-1:0];
    end
  end

  // ---------------- stage 2: second-level read ----------------
  logic [L2D_W-1:0] l2_rd;
  logic [L2A_W-1:0] l2_raddr;
  logic             s2_valid;
  logic [L1D_W-1:0] s2_l1;

  assign l2_raddr = {l1_rd[PTR_W-1:0], s1_low};

  lpm_ram #(.AW(L2A_W), .DW(L2D_W)) l2_ram_i (
    .clk   (clk),
    .we    (l2w_en),
    .waddr (l2w_addr),
    .wdata (l2w_data),
    .raddr (l2_raddr),
    .rdata (l2_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_l1    <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_l1    <= l1_rd;
    end
  end

  // ---------------- stage 3: select and register ----------------
  lpm_resolve #(.NH_W(NH_W), .DEFAULT_HOP(DEFAULT_HOP)) resolve_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (s2_valid),
    .in_l1_valid (s2_l1[L1D_W-1]),
    .in_l1_ptr   (s2_l1[L1D_W-2]),
    .in_l1_hop   (s2_l1[NH_W-1:0]),
    .in_l2_valid (l2_rd[L2D_W-1]),
    .in_l2_hop   (l2_rd[NH_W-1:0]),
    .out_valid   (res_valid),
    .out_hit     (res_hit),
    .out_hop     (res_hop)
  );
endmodule

// File: rtl/route_lookup_2lvl_checks.sv
module route_lookup_2lvl_checks #(
  parameter int              NH_W        = 8,
  parameter logic [NH_W-1:0] DEFAULT_HOP = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            res_valid,
  input logic            res_hit,
  input logic [NH_W-1:0] res_hop
);
  // R6: every request produces a result three cycles later
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##3 res_valid);

  // R6: no result without a request three cycles earlier
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid, 3));

  // R4: a miss always reports the default next hop
  a_r4_miss_default: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_hop == DEFAULT_HOP));

  // R10: output valid is low after a reset cycle
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> !res_valid);

  // R1: a result never carries unknown bits
  a_r1_known: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !$isunknown({res_hit, res_hop}));
endmodule

bind route_lookup_2lvl route_lookup_2lvl_checks #(
  .NH_W(NH_W), .DEFAULT_HOP(DEFAULT_HOP)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_hop   (res_hop)
);

// File: tb/route_lookup_2lvl_tb_top.sv
`timescale 1ns/1ps
module route_lookup_2lvl_tb_top;
  localparam int L1_W  = 6;
  localparam int L2_W  = 4;
  localparam int PTR_W = 2;
  localparam int NH_W  = 8;
  localparam logic [NH_W-1:0] DEF = 8'hEE;
  localparam int KEY_W = L1_W + L2_W;
  localparam int WA_W  = 6;
  localparam int PAY_W = 8;
  localparam int NKEYS = 1 << KEY_W;
  localparam int NP    = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [KEY_W-1:0] req_key = '0;
  logic             wr_en = 1'b0;
  logic             wr_level = 1'b0;
  logic [WA_W-1:0]  wr_addr = '0;
  logic             wr_valid = 1'b0;
  logic             wr_ptr = 1'b0;
  logic [PAY_W-1:0] wr_payload = '0;
  logic             res_valid;
  logic             res_hit;
  logic [NH_W-1:0]  res_hop;

  always #2.5 clk = ~clk;

  route_lookup_2lvl #(
    .L1_W(L1_W), .L2_W(L2_W), .PTR_W(PTR_W), .NH_W(NH_W), .DEFAULT_HOP(DEF)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_key(req_key),
    .wr_en(wr_en), .wr_level(wr_level), .wr_addr(wr_addr), .wr_valid(wr_valid),
    .wr_ptr(wr_ptr), .wr_payload(wr_payload),
    .res_valid(res_valid), .res_hit(res_hit), .res_hop(res_hop)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // route list: value (10-bit, left aligned), length, next hop
  int pval [NP];
  int plen [NP];
  int phop [NP];
  int blk_of [1 << L1_W];

  // expected-result queue
  int    e_hit [8192];
  int    e_hop [8192];
  int    e_cyc [8192];
  string e_tag [8192];
  int    head = 0;
  int    tail = 0;

  function automatic int lpm(input int key, input int maxlen);
    int best_len = -1;
    int best_hop = -1;
    for (int p = 0; p < NP; p++) begin
      if (plen[p] <= maxlen &&
          (key >> (KEY_W - plen[p])) == (pval[p] >> (KEY_W - plen[p])) &&
          plen[p] > best_len) begin
        best_len = plen[p];
        best_hop = phop[p];
      end
    end
    return best_hop;
  endfunction

  task automatic push(input int hit, input int hop, input string tag);
    e_hit[tail] = hit;
    e_hop[tail] = hop;
    e_cyc[tail] = cyc;
    e_tag[tail] = tag;
    tail++;
  endtask

  task automatic push_lpm(input int key);
    int h = lpm(key, KEY_W);
    if (h < 0) push(0, DEF, "R4");
    else       push(1, h, "R1");
  endtask

  // result monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (head == tail) begin
        checks++; fails++;
        $display("FAIL R6: unexpected result hit=%0d hop=%0h (expected none)", res_hit, res_hop);
      end else begin
        checks++;
        if (res_hit !== e_hit[head][0] || res_hop !== e_hop[head][NH_W-1:0]) begin
          fails++;
          $display("FAIL %s: result #%0d hit=%0d hop=%0h expected hit=%0d hop=%0h",
                   e_tag[head], head, res_hit, res_hop, e_hit[head], e_hop[head]);
        end
        checks++;
        if (cyc - e_cyc[head] != 3) begin
          fails++;
          $display("FAIL R6: latency %0d expected 3", cyc - e_cyc[head]);
        end
        head++;
      end
    end
  end

  task automatic idle();
    req_valid = 1'b0;
    wr_en     = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_write(input logic lvl, input int addr, input logic v,
                           input logic ptr, input int pay);
    wr_en      = 1'b1;
    wr_level   = lvl;
    wr_addr    = WA_W'(addr);
    wr_valid   = v;
    wr_ptr     = ptr;
    wr_payload = PAY_W'(pay);
  endtask

  task automatic write_one(input logic lvl, input int addr, input logic v,
                           input logic ptr, input int pay);
    set_write(lvl, addr, v, ptr, pay);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic build_tables();
    int nblk = 0;
    for (int i = 0; i < (1 << L1_W); i++) blk_of[i] = -1;
    for (int p = 0; p < NP; p++)
      if (plen[p] > L1_W && blk_of[pval[p] >> L2_W] < 0) begin
        blk_of[pval[p] >> L2_W] = nblk;
        nblk++;
      end
    // R9: short routes replicated first, pointer entries written afterwards
    for (int i = 0; i < (1 << L1_W); i++) begin
      int h = lpm(i << L2_W, L1_W);
      write_one(1'b0, i, h >= 0, 1'b0, (h >= 0) ? h : 0);
    end
    for (int i = 0; i < (1 << L1_W); i++)
      if (blk_of[i] >= 0) begin
        write_one(1'b0, i, 1'b1, 1'b1, blk_of[i]);
        for (int j = 0; j < (1 << L2_W); j++) begin
          int h = lpm((i << L2_W) | j, KEY_W);
          write_one(1'b1, (blk_of[i] << L2_W) | j, h >= 0, 1'b0, (h >= 0) ? h : 0);
        end
      end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete (expected completion)");
    finish_run();
  end

  initial begin
    pval[0] = 10'h100; plen[0] = 2;  phop[0] = 1;
    pval[1] = 10'h140; plen[1] = 4;  phop[1] = 2;
    pval[2] = 10'h180; plen[2] = 6;  phop[2] = 3;
    pval[3] = 10'h184; plen[3] = 8;  phop[3] = 4;
    pval[4] = 10'h186; plen[4] = 10; phop[4] = 5;
    pval[5] = 10'h200; plen[5] = 1;  phop[5] = 6;
    pval[6] = 10'h3F5; plen[6] = 10; phop[6] = 7;
    pval[7] = 10'h050; plen[7] = 7;  phop[7] = 8;

    // R10: quiet output during and right after reset
    repeat (4) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      fails++; $display("FAIL R10: res_valid=%b during reset expected 0", res_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      fails++; $display("FAIL R10: res_valid=%b after reset expected 0", res_valid);
    end

    build_tables();
    idle();

    // R1 R2 R3 R4 R5: every key, one per cycle
    for (int k = 0; k < NKEYS; k++) begin
      req_valid = 1'b1; req_key = KEY_W'(k);
      push_lpm(k);
      @(negedge clk);
    end
    idle();

    // R6: sparse requests with gaps of varying length
    for (int k = 0; k < NKEYS; k += 37) begin
      req_valid = 1'b1; req_key = KEY_W'(k);
      push_lpm(k);
      @(negedge clk);
      for (int g = 0; g < (k % 3); g++) idle();
    end
    repeat (5) idle();

    // R7/R8 first level: key 0x100 (index 16, direct hop 1)
    req_valid = 1'b1; req_key = 10'h100;
    set_write(1'b0, 16, 1'b1, 1'b0, 8'h55);
    push(1, 1, "R7");
    @(negedge clk);
    wr_en = 1'b0;
    req_key = 10'h100;
    push(1, 8'h55, "R8");
    @(negedge clk);
    idle();

    // R7/R8 second level: key 0x186 (block 0, low 6, hop 5)
    req_valid = 1'b1; req_key = 10'h186;
    set_write(1'b1, (blk_of[10'h186 >> L2_W] << L2_W) | 6, 1'b1, 1'b0, 8'h66);
    push(1, 5, "R7");
    @(negedge clk);
    wr_en = 1'b0;
    req_key = 10'h186;
    push(1, 8'h66, "R8");
    @(negedge clk);
    idle();

    // R9: repeated writes, last one wins (uncovered index 2)
    write_one(1'b0, 2, 1'b1, 1'b0, 8'h21);
    write_one(1'b0, 2, 1'b1, 1'b0, 8'h22);
    req_valid = 1'b1; req_key = 10'h02A;
    push(1, 8'h22, "R9");
    @(negedge clk);
    idle();

    // R2: direct entry ignores second-level contents at block 0 address
    write_one(1'b0, 16, 1'b1, 1'b0, 8'h00);
    req_valid = 1'b1; req_key = 10'h100;
    push(1, 0, "R2");
    @(negedge clk);
    idle();

    // R4: invalidate a direct entry, then a second-level entry
    write_one(1'b0, 16, 1'b0, 1'b0, 8'h77);
    write_one(1'b1, (blk_of[10'h3F5 >> L2_W] << L2_W) | 5, 1'b0, 1'b0, 8'h77);
    req_valid = 1'b1; req_key = 10'h10F;
    push(0, DEF, "R4");
    @(negedge clk);
    req_key = 10'h3F5;
    push(0, DEF, "R4");
    @(negedge clk);
    req_key = 10'h3F4;
    push(1, 6, "R3");
    @(negedge clk);
    repeat (6) idle();

    // R5: every request answered
    checks++;
    if (head != tail) begin
      fails++; $display("FAIL R5: %0d results outstanding expected 0", tail - head);
    end
    finish_run();
  end
endmodule